// File: doc/BRIEF.md
# Operand Read Delay Queue

This block sits between the register-bank read arbiter and the operand collector units. In each cycle it takes up to one granted read per register bank. Each read carries a collector identifier, an operand index and a lane activity mask. The block hands every read to its collector as a one-cycle delivery strobe. Delivery happens either in the grant cycle or a fixed number of cycles later. That number comes from a run-time latency input. It lets a model of the register-file pipeline vary the grant-to-arrival delay without changing the arbiter or the collectors.

When the latency is zero, reads bypass the storage entirely and the outputs match the undelayed path. When the latency is non-zero, reads wait in a first-in first-out store tagged with a ready time. The store is drained before new grants are written, so the head entries due in a cycle go out in that cycle. When the store cannot take a full cycle's worth of grants, a hold output asks the grant stage to stall. The block also counts register-file reads. The count can take clock-gated lane groups into account, so it reflects the lanes that were actually powered.

Top module: `opnd_read_delay_q`

## Requirements
- R1: With `lat` = 0, every valid grant appears on the delivery outputs combinationally in the same cycle, nothing is stored, and `hold` stays low.
- R2: In both modes, delivery slot k carries the k-th delivered read. The grants of one cycle are ordered by ascending bank index, so slots 0..n-1 are valid and the higher slots are idle.
- R3: With `lat` = L > 0, a read granted in cycle t is delivered in cycle t+L and never earlier. In particular, nothing is delivered in the grant cycle.
- R4: Reads granted in different cycles are delivered in grant order. An older batch is never overtaken by a younger one.
- R5: `hold` is high while fewer than NB entries are free in the store. Grants presented while `hold` is high are dropped and are never delivered.
- R6: With `gate_en` = 1, each delivered read adds GRP times the number of lane groups that have at least one active lane. Group g covers mask bits g*GRP to g*GRP+GRP-1. The total `rd_count` shows the sum one clock edge after delivery.
- R7: With `gate_en` = 0, each delivered read adds WARP to `rd_count`, whatever its mask. A cycle without deliveries leaves `rd_count` unchanged.
- R8: After reset, `dlv_vld` is zero, `hold` is low and `rd_count` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat | input | LAT_W | Grant-to-delivery delay in cycles; 0 selects bypass |
| gate_en | input | 1 | Count reads per active lane group instead of per full warp |
| gnt_vld | input | NB | Per-bank grant valid |
| gnt_cu | input | NB*CU_W | Per-bank collector identifier |
| gnt_op | input | NB*OP_W | Per-bank operand index |
| gnt_mask | input | NB*WARP | Per-bank lane activity mask |
| hold | output | 1 | Store nearly full; grant stage must stall |
| dlv_vld | output | NB | Per-slot delivery strobe |
| dlv_cu | output | NB*CU_W | Per-slot collector identifier |
| dlv_op | output | NB*OP_W | Per-slot operand index |
| rd_count | output | CNT_W | Cumulative register-file read count |

## Verification
Some properties are checked on every cycle by the assertions. The store never exceeds its depth. The bypass mode never fills it. A held cycle never grows the occupancy. Delivery slots are always packed from slot 0. An empty store in delayed mode delivers nothing. The read count only moves in cycles with deliveries. Other behaviour needs the bench's scenarios. These cover exact arrival cycles for a given latency, ordering between batches from different cycles, and the dropping of grants under hold. They also cover the per-group counting arithmetic for specific masks.

// File: rtl/opnd_read_delay_q.sv
module opnd_read_delay_q #(
  parameter int NB    = 4,
  parameter int CU_W  = 3,
  parameter int OP_W  = 2,
  parameter int WARP  = 32,
  parameter int GRP   = 4,
  parameter int DEPTH = 16,
  parameter int LAT_W = 4,
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LAT_W-1:0]    lat,
  input  logic                gate_en,
  input  logic [NB-1:0]       gnt_vld,
  input  logic [NB*CU_W-1:0]  gnt_cu,
  input  logic [NB*OP_W-1:0]  gnt_op,
  input  logic [NB*WARP-1:0]  gnt_mask,
  output logic                hold,
  output logic [NB-1:0]       dlv_vld,
  output logic [NB*CU_W-1:0]  dlv_cu,
  output logic [NB*OP_W-1:0]  dlv_op,
  output logic [CNT_W-1:0]    rd_count
);
  // DEPTH must be a power of two so the pointers wrap naturally.
  localparam int PW = $clog2(DEPTH);
  localparam int QW = $clog2(DEPTH + 1);
  localparam int TW = LAT_W + 1;
  localparam int KW = $clog2(NB + 1);
  localparam int SW = (NB > 1) ? $clog2(NB) : 1;
  localparam int NG = WARP / GRP;
  localparam int IW = $clog2(NB * WARP + 1);

  logic [CU_W-1:0] q_cu   [DEPTH];
  logic [OP_W-1:0] q_op   [DEPTH];
  logic [WARP-1:0] q_mask [DEPTH];
  logic [TW-1:0]   q_ts   [DEPTH];

  logic [PW-1:0] wp, rp;
  logic [QW-1:0] cnt;
  logic [TW-1:0] now;

  logic [NB-1:0]   pk_vld;
  logic [CU_W-1:0] pk_cu   [NB];
  logic [OP_W-1:0] pk_op   [NB];
  logic [WARP-1:0] pk_mask [NB];
  logic [KW-1:0]   n_gnt;

  logic [NB-1:0]   hd_vld;
  logic [CU_W-1:0] hd_cu   [NB];
  logic [OP_W-1:0] hd_op   [NB];
  logic [WARP-1:0] hd_mask [NB];

  logic [WARP-1:0] sel_mask [NB];
  logic            bypass, accept;
  logic [KW-1:0]   n_drn;
  logic [IW-1:0]   inc;

  function automatic int act_groups(input logic [WARP-1:0] m);
    int c;
    c = 0;
    for (int g = 0; g < NG; g++)
      if (|m[g*GRP +: GRP]) c++;
    return c;
  endfunction

  assign bypass = (lat == '0);
  assign hold   = cnt > QW'(DEPTH - NB);
  assign accept = !bypass && !hold;

  always_comb begin
    pk_vld = '0;
    n_gnt  = '0;
    for (int k = 0; k < NB; k++) begin
      pk_cu[k]   = '0;
      pk_op[k]   = '0;
      pk_mask[k] = '0;
    end
    for (int i = 0; i < NB; i++) begin
      if (gnt_vld[i]) begin
        pk_vld[n_gnt[SW-1:0]]  = 1'b1;
        pk_cu[n_gnt[SW-1:0]]   = gnt_cu[i*CU_W +: CU_W];
        pk_op[n_gnt[SW-1:0]]   = gnt_op[i*OP_W +: OP_W];
        pk_mask[n_gnt[SW-1:0]] = gnt_mask[i*WARP +: WARP];
        n_gnt = n_gnt + 1'b1;
      end
    end
  end

  always_comb begin
    logic [PW-1:0] idx;
    logic [TW-1:0] age;
    for (int k = 0; k < NB; k++) begin
      idx        = rp + PW'(k);
      age        = now - q_ts[idx];
      hd_vld[k]  = (QW'(k) < cnt) && !age[TW-1];
      hd_cu[k]   = q_cu[idx];
      hd_op[k]   = q_op[idx];
      hd_mask[k] = q_mask[idx];
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_slot
    assign dlv_vld[k]              = bypass ? pk_vld[k]  : hd_vld[k];
    assign dlv_cu[k*CU_W +: CU_W]  = bypass ? pk_cu[k]   : hd_cu[k];
    assign dlv_op[k*OP_W +: OP_W]  = bypass ? pk_op[k]   : hd_op[k];
    assign sel_mask[k]             = bypass ? pk_mask[k] : hd_mask[k];
  end

  assign n_drn = bypass ? '0 : KW'($countones(hd_vld));

  always_comb begin
    inc = '0;
    for (int k = 0; k < NB; k++)
      if (dlv_vld[k])
        inc = inc + (gate_en ? IW'(GRP * act_groups(sel_mask[k])) : IW'(WARP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      now      <= '0;
      rd_count <= '0;
    end else begin
      now      <= now + 1'b1;
      rd_count <= rd_count + CNT_W'(inc);
      rp       <= rp + PW'(n_drn);
      cnt      <= cnt + (accept ? QW'(n_gnt) : QW'(0)) - QW'(n_drn);
      if (accept) wp <= wp + PW'(n_gnt);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NB; k++) begin
      if (accept && pk_vld[k]) begin
        q_cu[wp + PW'(k)]   <= pk_cu[k];
        q_op[wp + PW'(k)]   <= pk_op[k];
        q_mask[wp + PW'(k)] <= pk_mask[k];
        q_ts[wp + PW'(k)]   <= now + TW'(lat);
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= QW'(DEPTH));

  a_r1_bypass_unqueued: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && cnt == '0) |=> cnt == '0);

  a_r5_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> cnt <= $past(cnt));

  a_r3_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && cnt == '0) |-> dlv_vld == '0);

  a_r7_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_vld == '0) |=> $stable(rd_count));

  for (genvar k = 1; k < NB; k++) begin : g_pack_chk
    a_r2_packed_slots: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_vld[k] |-> dlv_vld[k-1]);
  end
endmodule

// File: tb/tb_opnd_read_delay_q.sv
module tb_opnd_read_delay_q;
  localparam int NB = 4, CU_W = 3, OP_W = 2, WARP = 32, CNT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] lat = '0;
  logic gate_en = 1'b0;
  logic [NB-1:0] gnt_vld = '0;
  logic [NB*CU_W-1:0] gnt_cu = '0;
  logic [NB*OP_W-1:0] gnt_op = '0;
  logic [NB*WARP-1:0] gnt_mask = '0;
  logic hold;
  logic [NB-1:0] dlv_vld;
  logic [NB*CU_W-1:0] dlv_cu;
  logic [NB*OP_W-1:0] dlv_op;
  logic [CNT_W-1:0] rd_count;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  opnd_read_delay_q dut (
    .clk(clk), .rst_n(rst_n), .lat(lat), .gate_en(gate_en),
    .gnt_vld(gnt_vld), .gnt_cu(gnt_cu), .gnt_op(gnt_op), .gnt_mask(gnt_mask),
    .hold(hold), .dlv_vld(dlv_vld), .dlv_cu(dlv_cu), .dlv_op(dlv_op),
    .rd_count(rd_count));

  localparam int NV = 7;
  localparam logic [3:0]  V_VLD  [NV] = '{4'b0001, 4'b1010, 4'b1111, 4'b0100, 4'b0110, 4'b0000, 4'b1001};
  localparam logic [31:0] V_MASK [NV] = '{32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0011, 32'h0,
                                          32'h0, 32'hFFFF_FFFF, 32'hF0F0_F0F0};
  localparam logic        V_GATE [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int          V_INC  [NV] = '{32, 8, 48, 0, 64, 0, 32};
  localparam logic [3:0]  V_DLV  [NV] = '{4'b0001, 4'b0011, 4'b1111, 4'b0001, 4'b0011, 4'b0000, 4'b0011};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    gnt_vld = '0; gnt_cu = '0; gnt_op = '0; gnt_mask = '0;
  endtask

  task automatic put(input int b, input logic [CU_W-1:0] cu, input logic [OP_W-1:0] op,
                     input logic [WARP-1:0] m);
    gnt_vld[b] = 1'b1;
    gnt_cu[b*CU_W +: CU_W] = cu;
    gnt_op[b*OP_W +: OP_W] = op;
    gnt_mask[b*WARP +: WARP] = m;
  endtask

  initial begin
    #1_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] base;
    int delivered;
    bit saw7;
    repeat (3) @(negedge clk);
    chk("R8 dlv_vld", 64'(dlv_vld), 0);
    chk("R8 hold", 64'(hold), 0);
    chk("R8 rd_count", 64'(rd_count), 0);
    rst_n = 1'b1;

    // Bypass table: bank b carries collector b+1, operand b
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      clr();
      gate_en = V_GATE[v];
      for (int b = 0; b < NB; b++)
        if (V_VLD[v][b]) put(b, CU_W'(b + 1), OP_W'(b), V_MASK[v]);
      #1;
      chk("R1 same-cycle delivery", 64'(dlv_vld), 64'(V_DLV[v]));
      chk("R1 hold low", 64'(hold), 0);
      begin
        int s;
        s = 0;
        for (int b = 0; b < NB; b++)
          if (V_VLD[v][b]) begin
            chk("R2 slot cu", 64'(dlv_cu[s*CU_W +: CU_W]), 64'(b + 1));
            chk("R2 slot op", 64'(dlv_op[s*OP_W +: OP_W]), 64'(b));
            s++;
          end
      end
      base = rd_count;
      @(posedge clk); #1;
      chk(V_GATE[v] ? "R6 gated count" : "R7 full count", 64'(rd_count), 64'(base + V_INC[v]));
    end

    // Latency 3
    @(negedge clk);
    clr(); lat = 4'd3; gate_en = 1'b0;
    put(1, 3'd5, 2'd1, '1);
    put(3, 3'd6, 2'd2, '1);
    #1;
    chk("R3 not in grant cycle", 64'(dlv_vld), 0);
    base = rd_count;
    @(negedge clk); clr(); #1;
    chk("R3 early t+1", 64'(dlv_vld), 0);
    @(negedge clk); #1;
    chk("R3 early t+2", 64'(dlv_vld), 0);
    @(negedge clk); #1;
    chk("R3 at t+3", 64'(dlv_vld), 64'h3);
    chk("R3 slot0 cu", 64'(dlv_cu[0 +: CU_W]), 5);
    chk("R3 slot1 cu", 64'(dlv_cu[CU_W +: CU_W]), 6);
    @(posedge clk); #1;
    chk("R7 delayed count", 64'(rd_count), 64'(base + 64));
    @(negedge clk); #1;
    chk("R3 single delivery", 64'(dlv_vld), 0);

    // Latency 1, two batches
    @(negedge clk);
    lat = 4'd1;
    put(0, 3'd1, 2'd0, '1);
    @(negedge clk);
    clr();
    put(2, 3'd2, 2'd0, '1);
    put(3, 3'd3, 2'd0, '1);
    #1;
    chk("R4 first batch", 64'(dlv_vld), 64'h1);
    chk("R4 first cu", 64'(dlv_cu[0 +: CU_W]), 1);
    @(negedge clk); clr(); #1;
    chk("R4 second batch", 64'(dlv_vld), 64'h3);
    chk("R4 second cu0", 64'(dlv_cu[0 +: CU_W]), 2);
    chk("R4 second cu1", 64'(dlv_cu[CU_W +: CU_W]), 3);
    @(negedge clk); #1;
    chk("R4 drained", 64'(dlv_vld), 0);

    // Fill to hold with latency 15
    @(negedge clk);
    lat = 4'd15;
    base = rd_count;
    for (int c = 0; c < 4; c++) begin
      clr();
      for (int b = 0; b < NB; b++) put(b, CU_W'(b), 2'd0, '1);
      #1;
      chk("R5 hold low while room", 64'(hold), 0);
      @(negedge clk);
    end
    clr();
    put(0, 3'd7, 2'd3, '1);
    #1;
    chk("R5 hold when full", 64'(hold), 1);
    delivered = 0;
    saw7 = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      clr();
      #1;
      delivered += $countones(dlv_vld);
      for (int s = 0; s < NB; s++)
        if (dlv_vld[s] && dlv_cu[s*CU_W +: CU_W] == 3'd7) saw7 = 1'b1;
    end
    chk("R5 delivered count", 64'(delivered), 16);
    chk("R5 dropped grant absent", 64'(saw7), 0);
    chk("R5 hold released", 64'(hold), 0);
    chk("R7 count after fill", 64'(rd_count), 64'(base + 512));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule